// File: doc/BRIEF.md
# Low-Power Stop and Clock-Loss Controller

This controller decides when the system clock may run and what happens when the primary clock disappears. A one-cycle stop command from the processor closes the system clock gate and parks the block in a stopped state. An interrupt request or an external reset ends the stop. Every decision is taken on a free-running monitor clock, so the controller keeps working while the system clock is gated off. When the gate reopens, the enable passes through a short synchroniser so that the first clock pulse after the stop is never cut short.

A clock-monitor loss flag is handled by a policy bit. With the policy bit clear, the block switches to the alternate clock and keeps running. With it set, the block raises a reset request. While stopped, a loss is only acted on when the backup RC oscillator is on. That is true when software has enabled it or when the block has forced it on. An external reset that arrives while the oscillator is disabled forces it back on, so the reset can still be seen.

Each downstream module also has its own stop bit. A module's clock enable is the system clock enable masked by that bit.

Top module: `lpstop_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `sys_clk_en`, `clk_sel`, `reset_req` and `rc_force` are all 0 and the block is in its running state. `sys_clk_en` becomes 1 once `SYNC_STAGES` (default 2) rising edges have been sampled in the running state.
- R2: In the running state, a `stop_cmd` sampled high with no loss-reset and no `ext_reset` moves the block to the stopped state. `sys_clk_en` is 0 from the next cycle and stays 0 while stopped.
- R3: After any entry into the running state, `sys_clk_en` stays 0 for exactly `SYNC_STAGES` edges and then rises. It falls in the same cycle the running state is left.
- R4: An `irq_req` sampled high while stopped, or while stopped on the alternate clock, returns the block to the running state. This applies when neither `ext_reset` nor an acted-on loss is present.
- R5: While stopped, with the RC oscillator on and `rst_on_loss`=0, a `clk_lost` sampled high sets `clk_sel` to 1 (1 = alternate clock). The block stays stopped with the gate closed.
- R6: `clk_lost` with `rst_on_loss`=1 raises `reset_req` in the next cycle. This holds in the running state, and in the stopped state when the RC oscillator is on.
- R7: While stopped with the RC oscillator off (`rc_en`=0 and `rc_force`=0), `clk_lost` is ignored. The block stays stopped, `clk_sel` is unchanged and `reset_req` stays 0.
- R8: `ext_reset` sampled high in any state drives `reset_req` to 1 in the next cycle, ahead of every other input.
- R9: `ext_reset` sampled high while `rc_en`=0 sets `rc_force` in the next cycle. It stays set until the reset request ends.
- R10: `reset_req` ends after `RST_HOLD` (default 4) consecutive edges with `ext_reset` low. At that edge, `rc_force` clears and `clk_sel` takes the value of `clk_lost`.
- R11: In the running state with `rst_on_loss`=0, `clk_lost` sets `clk_sel` to 1. The block keeps running and still honours `stop_cmd`.
- R12: `mod_clk_en[i]` equals `sys_clk_en` AND NOT `mod_stop[i]` for every module i.
- R13: While stopped, an acted-on loss takes priority over a simultaneous `irq_req`. In the running state, a loss with `rst_on_loss`=1 takes priority over `stop_cmd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running monitor clock |
| rst | input | 1 | Synchronous active-high block reset |
| stop_cmd | input | 1 | Processor low-power stop command |
| irq_req | input | 1 | Interrupt request that ends a stop |
| ext_reset | input | 1 | External reset pin, synchronised |
| clk_lost | input | 1 | Clock-monitor loss flag |
| rc_en | input | 1 | Software enable of the backup RC oscillator |
| rst_on_loss | input | 1 | Clock-loss policy: 1 = reset, 0 = alternate clock |
| mod_stop | input | NMOD | Per-module stop bits |
| sys_clk_en | output | 1 | System clock gate enable |
| clk_sel | output | 1 | Clock select, 1 = alternate clock |
| reset_req | output | 1 | Reset request to the system |
| rc_force | output | 1 | Forces the RC oscillator on |
| mod_clk_en | output | NMOD | Per-module clock enables |

## Verification
The bound checker tests these rules on every cycle:
- an external reset is always followed by a reset request;
- the loss-reset policy holds in the running state;
- a loss with the oscillator off is ignored in stop;
- the gate never rises without two prior running cycles;
- the alternate-clock stop keeps the gate closed with the alternate select set.

Some properties are only visible in the bench's sequences:
- the exact length of the reset hold;
- the value `clk_sel` takes on reset release;
- the stop-then-resume paths through the alternate clock;
- the way priorities resolve when several inputs arrive together.

The bench drives these through directed cases and long random runs against a cycle model.

// File: rtl/lpstop_pkg.sv
package lpstop_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_STOP   = 2'd1,
        ST_ALT    = 2'd2,
        ST_RSTREQ = 2'd3
    } lp_state_e;

    typedef struct packed {
        logic stop_cmd;
        logic irq;
        logic ext_rst;
        logic clk_lost;
        logic rc_en;
        logic rst_on_loss;
    } lp_ctl_s;

    // A loss is acted on while running, or while stopped with the RC oscillator on.
    function automatic logic loss_seen(lp_state_e st, logic lost, logic rc_on);
        return lost && ((st == ST_RUN) || ((st == ST_STOP) && rc_on));
    endfunction

endpackage

// File: rtl/lpstop_fsm.sv
module lpstop_fsm
    import lpstop_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lp_ctl_s   ctl,
    input  logic      hold_done,
    output lp_state_e state_q,
    output logic      clk_sel_q,
    output logic      rc_force_q
);

    lp_state_e nxt_state;
    logic      nxt_sel;
    logic      nxt_force;
    logic      rc_on;
    logic      lost;

    always_comb begin
        nxt_state = state_q;
        nxt_sel   = clk_sel_q;
        rc_on     = ctl.rc_en | rc_force_q;
        lost      = loss_seen(state_q, ctl.clk_lost, rc_on);
        case (state_q)
            ST_RUN: begin
                if (ctl.ext_rst) begin
                    nxt_state = ST_RSTREQ;
                end else if (lost && ctl.rst_on_loss) begin
                    nxt_state = ST_RSTREQ;
                end else begin
                    if (lost) nxt_sel = 1'b1;
                    if (ctl.stop_cmd) nxt_state = ST_STOP;
                end
            end
            ST_STOP: begin
                if (ctl.ext_rst) begin
                    nxt_state = ST_RSTREQ;
                end else if (lost && ctl.rst_on_loss) begin
                    nxt_state = ST_RSTREQ;
                end else if (lost) begin
                    nxt_state = ST_ALT;
                    nxt_sel   = 1'b1;
                end else if (ctl.irq) begin
                    nxt_state = ST_RUN;
                end
            end
            ST_ALT: begin
                if (ctl.ext_rst) nxt_state = ST_RSTREQ;
                else if (ctl.irq) nxt_state = ST_RUN;
            end
            ST_RSTREQ: begin
                if (hold_done) begin
                    nxt_state = ST_RUN;
                    nxt_sel   = ctl.clk_lost;
                end
            end
            default: nxt_state = ST_RUN;
        endcase

        nxt_force = rc_force_q;
        if ((state_q == ST_RSTREQ) && hold_done) nxt_force = 1'b0;
        else if (ctl.ext_rst && !ctl.rc_en) nxt_force = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_RUN;
            clk_sel_q  <= 1'b0;
            rc_force_q <= 1'b0;
        end else begin
            state_q    <= nxt_state;
            clk_sel_q  <= nxt_sel;
            rc_force_q <= nxt_force;
        end
    end

endmodule

// File: rtl/lpstop_gate.sv
module lpstop_gate #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic en
);

    logic [STAGES-1:0] sync_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst || !req) sync_q <= '0;
                else sync_q <= 1'b1;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst || !req) sync_q <= '0;
                else sync_q <= {sync_q[STAGES-2:0], 1'b1};
            end
        end
    endgenerate

    // Opening waits for the chain; closing follows the request at once.
    assign en = req & sync_q[STAGES-1];

endmodule

// File: rtl/lpstop_rst_hold.sv
module lpstop_rst_hold #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic ext_rst,
    output logic done
);

    localparam int CW = $clog2(HOLD) + 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !active || ext_rst) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
    end

    assign done = active && !ext_rst && (cnt_q == CW'(HOLD - 1));

endmodule

// File: rtl/lpstop_ctrl.sv
module lpstop_ctrl
    import lpstop_pkg::*;
#(
    parameter int NMOD        = 4,
    parameter int SYNC_STAGES = 2,
    parameter int RST_HOLD    = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stop_cmd,
    input  logic            irq_req,
    input  logic            ext_reset,
    input  logic            clk_lost,
    input  logic            rc_en,
    input  logic            rst_on_loss,
    input  logic [NMOD-1:0] mod_stop,
    output logic            sys_clk_en,
    output logic            clk_sel,
    output logic            reset_req,
    output logic            rc_force,
    output logic [NMOD-1:0] mod_clk_en
);

    lp_ctl_s   ctl;
    lp_state_e state_q;
    logic      hold_done;
    logic      run_req;

    assign ctl = '{stop_cmd:    stop_cmd,
                   irq:         irq_req,
                   ext_rst:     ext_reset,
                   clk_lost:    clk_lost,
                   rc_en:       rc_en,
                   rst_on_loss: rst_on_loss};

    lpstop_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .hold_done  (hold_done),
        .state_q    (state_q),
        .clk_sel_q  (clk_sel),
        .rc_force_q (rc_force)
    );

    lpstop_rst_hold #(.HOLD(RST_HOLD)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .active  (state_q == ST_RSTREQ),
        .ext_rst (ext_reset),
        .done    (hold_done)
    );

    assign run_req = (state_q == ST_RUN);

    lpstop_gate #(.STAGES(SYNC_STAGES)) u_gate (
        .clk (clk),
        .rst (rst),
        .req (run_req),
        .en  (sys_clk_en)
    );

    assign reset_req = (state_q == ST_RSTREQ);

    generate
        for (genvar i = 0; i < NMOD; i++) begin : g_mod
            assign mod_clk_en[i] = sys_clk_en & ~mod_stop[i];
        end
    endgenerate

endmodule

// File: rtl/lpstop_ctrl_chk.sv
module lpstop_ctrl_chk
    import lpstop_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      ext_reset,
    input logic      clk_lost,
    input logic      rc_en,
    input logic      rst_on_loss,
    input logic      irq_req,
    input logic      sys_clk_en,
    input logic      clk_sel,
    input logic      reset_req,
    input logic      rc_force,
    input lp_state_e st
);

    // R8
    ext_reset_req_chk: assert property (@(posedge clk) disable iff (rst)
        ext_reset |=> reset_req);

    // R6
    run_loss_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN) && clk_lost && rst_on_loss |=> reset_req);

    // R7
    stop_loss_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_STOP) && clk_lost && !(rc_en || rc_force) && !ext_reset && !irq_req
        |=> (st == ST_STOP) && $stable(clk_sel) && !reset_req);

    // R3
    gate_open_sync_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_clk_en) |-> $past(st == ST_RUN, 1) && $past(st == ST_RUN, 2));

    // R9
    rc_force_set_chk: assert property (@(posedge clk) disable iff (rst)
        ext_reset && !rc_en |=> rc_force);

    // R5
    alt_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ALT) |-> clk_sel && !sys_clk_en);

    // R2
    stop_gate_closed_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_STOP) |-> !sys_clk_en);

endmodule

bind lpstop_ctrl lpstop_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ext_reset   (ext_reset),
    .clk_lost    (clk_lost),
    .rc_en       (rc_en),
    .rst_on_loss (rst_on_loss),
    .irq_req     (irq_req),
    .sys_clk_en  (sys_clk_en),
    .clk_sel     (clk_sel),
    .reset_req   (reset_req),
    .rc_force    (rc_force),
    .st          (state_q)
);

// File: tb/lpstop_ctrl_test.sv
module lpstop_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NMOD       = 4;
    localparam int SYNC       = 2;
    localparam int HOLD       = 4;

    logic            clk = 1'b0;
    logic            rst;
    logic            stop_cmd, irq_req, ext_reset, clk_lost, rc_en, rst_on_loss;
    logic [NMOD-1:0] mod_stop;
    logic            sys_clk_en, clk_sel, reset_req, rc_force;
    logic [NMOD-1:0] mod_clk_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Cycle model: 0 run, 1 stop, 2 stop on alternate clock, 3 reset request
    int   m_st, m_run, m_cnt;
    logic m_sel, m_force;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpstop_ctrl #(.NMOD(NMOD), .SYNC_STAGES(SYNC), .RST_HOLD(HOLD)) uut (
        .clk, .rst, .stop_cmd, .irq_req, .ext_reset, .clk_lost, .rc_en,
        .rst_on_loss, .mod_stop, .sys_clk_en, .clk_sel, .reset_req,
        .rc_force, .mod_clk_en
    );

    function automatic logic exp_gate();
        return (m_st == 0) && (m_run == SYNC);
    endfunction

    task automatic model_step();
        logic rc_on, lost, done;
        int   ns;
        logic nsel, nforce;
        if (rst) begin
            m_st = 0; m_run = 0; m_cnt = 0; m_sel = 0; m_force = 0;
            return;
        end
        rc_on  = rc_en | m_force;
        lost   = clk_lost && (m_st == 0 || (m_st == 1 && rc_on));
        done   = (m_st == 3) && !ext_reset && (m_cnt == HOLD - 1);
        ns     = m_st;
        nsel   = m_sel;
        nforce = m_force;
        if (done) nforce = 0;
        else if (ext_reset && !rc_en) nforce = 1;
        case (m_st)
            0: if (ext_reset || (lost && rst_on_loss)) ns = 3;
               else begin
                   if (lost) nsel = 1;
                   if (stop_cmd) ns = 1;
               end
            1: if (ext_reset || (lost && rst_on_loss)) ns = 3;
               else if (lost) begin ns = 2; nsel = 1; end
               else if (irq_req) ns = 0;
            2: if (ext_reset) ns = 3;
               else if (irq_req) ns = 0;
            default: if (done) begin ns = 0; nsel = clk_lost; end
        endcase
        m_run   = (m_st == 0) ? ((m_run < SYNC) ? m_run + 1 : SYNC) : 0;
        m_cnt   = (m_st != 3 || ext_reset) ? 0 : m_cnt + 1;
        m_st    = ns;
        m_sel   = nsel;
        m_force = nforce;
    endtask

    task automatic check(string tag, string name, logic [NMOD-1:0] act, logic [NMOD-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, name, act, exp, $time);
        end
    endtask

    task automatic compare(string tag);
        check(tag, "sys_clk_en", {{(NMOD-1){1'b0}}, sys_clk_en}, {{(NMOD-1){1'b0}}, exp_gate()});
        check(tag, "clk_sel",    {{(NMOD-1){1'b0}}, clk_sel},    {{(NMOD-1){1'b0}}, m_sel});
        check(tag, "reset_req",  {{(NMOD-1){1'b0}}, reset_req},  {{(NMOD-1){1'b0}}, m_st == 3});
        check(tag, "rc_force",   {{(NMOD-1){1'b0}}, rc_force},   {{(NMOD-1){1'b0}}, m_force});
        check(tag, "mod_clk_en", mod_clk_en, {NMOD{exp_gate()}} & ~mod_stop);
    endtask

    task automatic tick(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic drive(logic s, logic i, logic e, logic l, logic rce, logic ron);
        stop_cmd = s; irq_req = i; ext_reset = e; clk_lost = l; rc_en = rce; rst_on_loss = ron;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1a2b3c4d));
        rst = 1; mod_stop = '0;
        drive(0, 0, 0, 0, 1, 0);
        repeat (3) tick("R1");
        rst = 0;
        tick("R1");
        repeat (3) tick("R1 R3");

        // R2 stop, then R4 wake
        drive(1, 0, 0, 0, 1, 0); tick("R2");
        drive(0, 0, 0, 0, 1, 0); repeat (3) tick("R2");
        drive(0, 1, 0, 0, 1, 0); tick("R4");
        drive(0, 0, 0, 0, 1, 0); repeat (3) tick("R3");

        // R7 loss ignored in stop with RC off
        drive(1, 0, 0, 0, 0, 1); tick("R2");
        drive(0, 0, 0, 1, 0, 1); repeat (4) tick("R7");
        drive(0, 1, 0, 1, 0, 1); tick("R4");
        drive(0, 0, 0, 0, 0, 0); repeat (3) tick("R3");

        // R5 loss in stop goes to alternate clock, R4 wake from there
        drive(1, 0, 0, 0, 1, 0); tick("R2");
        drive(0, 0, 0, 1, 1, 0); repeat (3) tick("R5");
        drive(0, 1, 0, 0, 1, 0); tick("R4");
        drive(0, 0, 0, 0, 1, 0); repeat (3) tick("R5 R3");

        // R8 R9 R10 external reset with RC disabled
        drive(0, 0, 1, 0, 0, 0); repeat (3) tick("R8 R9");
        drive(0, 0, 0, 1, 0, 0); repeat (HOLD + 2) tick("R10");
        drive(0, 0, 0, 0, 1, 0); repeat (3) tick("R11");

        // R6 loss with reset policy while running
        drive(0, 0, 0, 1, 1, 1); tick("R6");
        drive(0, 0, 0, 0, 1, 1); repeat (HOLD + 3) tick("R10");

        // R13 loss beats irq in stop; loss-reset beats stop_cmd in run
        drive(1, 0, 0, 0, 1, 1); tick("R2");
        drive(0, 1, 0, 1, 1, 1); tick("R13");
        drive(0, 0, 0, 0, 1, 1); repeat (HOLD + 3) tick("R10");
        drive(1, 0, 0, 1, 1, 1); tick("R13");
        drive(0, 0, 0, 0, 1, 0); repeat (HOLD + 3) tick("R10");

        // R11 loss while running keeps running on the alternate clock
        drive(0, 0, 0, 1, 1, 0); repeat (2) tick("R11");
        drive(1, 0, 0, 1, 1, 0); tick("R11 R2");
        drive(0, 1, 0, 0, 1, 0); tick("R4");

        // R12 per-module masks
        drive(0, 0, 0, 0, 1, 0);
        for (int k = 0; k < (1 << NMOD); k++) begin
            mod_stop = k[NMOD-1:0];
            tick("R12");
        end

        // Constrained random segments
        for (int seg = 0; seg < 40; seg++) begin
            rc_en       = $urandom_range(0, 1);
            rst_on_loss = $urandom_range(0, 1);
            for (int c = 0; c < 200; c++) begin
                stop_cmd  = ($urandom_range(0, 7) == 0);
                irq_req   = ($urandom_range(0, 15) == 0);
                ext_reset = ($urandom_range(0, 149) == 0);
                if ($urandom_range(0, 19) == 0) clk_lost = ~clk_lost;
                mod_stop  = NMOD'($urandom);
                tick("R5 R6 R7 R11 R12 random");
            end
        end

        finish_run();
    end

endmodule